// File: doc/BRIEF.md
# Device Power State Controller

This block tracks and drives the power state of a single peripheral. A host-side request port carries two kinds of request: a query, which asks whether a move to a given state is possible now, and a set, which performs the move. The block sequences each move with the device. On the way down it strobes save-context before the state changes. On the way up it changes the state first and strobes restore-context afterwards.

While the device is away from full power, I/O requests from the requester side are held in a short in-order queue and released toward the device once it is back at full power. A positive query also holds I/O, and it refuses any request for a different state until the matching set arrives. One wake arm may be outstanding at a time. It completes when an external wake event occurs, or it fails when wake capability is withdrawn. An armed wake event also brings the device back to full power from any low state, and it is the only way out of the unpowered state. A saturating counter records how many times the device has gone deeper, so the host can tell whether a sleep request took effect.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state is full power (code 0), the entry counter is 0, save-context, restore-context, response and I/O output are low, and reqReady is high.
- R2: State codes are 0 full power, 1 light sleep, 2 deeper sleep, 3 powered-off-to-bus, 4 unpowered. A query (reqOp=0) is answered with rspValid in the cycle after it is accepted. rspOk is 1 only if the target code is 0 to 3, the target is supported, the current state is not 4, and no other target is locked.
- R3: A positive query locks its target. Until a set (reqOp=1) to that same target is accepted, a query or set for any other target gets rspOk=0, and incoming I/O stays in the queue and is not released.
- R4: A set to a deeper state raises saveCtx for exactly one cycle, starting the cycle after acceptance. The state changes in the following cycle, together with rspValid and rspOk=1.
- R5: A set to a shallower state changes the state in the cycle after acceptance. In the following cycle restoreCtx and rspValid with rspOk=1 are high for one cycle.
- R6: A set to target 3 from full power lands in state 3. A set to code 4 or above is refused. While in state 3 with auxPowerOff high, the block moves to state 4 without counting an entry.
- R7: A set to code 1 with capD1 low, or to code 2 with capD2 low, is refused with rspOk=0. The state is left unchanged and no context strobe is raised.
- R8: In state 4 every set is refused. Only a wake event with a wake armed returns the device to code 0, followed one cycle later by a restoreCtx pulse.
- R9: I/O requests that arrive outside full power are queued and released in arrival order after the return to code 0. None is lost, and ioOutValid is never high outside code 0.
- R10: The queue holds 4 entries. With 4 entries held, ioInReady is low and further requests are not taken.
- R11: Only one wake arm may be pending. A second arm while one is pending is ignored. A wake event completes the pending arm with wakeDone and wakeOk=1. Dropping capWake completes it with wakeOk=0. Arming with capWake low completes at once with wakeOk=0.
- R12: The entry counter rises by one on every move to a deeper state made by a set. It is CNT_W bits wide (16 by default) and holds at its maximum value.
- R13: A wake event with a wake armed returns the device from state 1, 2 or 3 to code 0 with a restoreCtx pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capD1 | input | 1 | Device supports state 1 |
| capD2 | input | 1 | Device supports state 2 |
| capWake | input | 1 | Device can raise a wake |
| auxPowerOff | input | 1 | Auxiliary power removed (moves state 3 to 4) |
| reqValid | input | 1 | Host power request valid |
| reqOp | input | 1 | 0 query, 1 set |
| reqTarget | input | 3 | Target state code |
| reqReady | output | 1 | Request accepted this cycle if valid |
| rspValid | output | 1 | Response pulse |
| rspOk | output | 1 | Response success |
| wakeArm | input | 1 | Arm a wake (pulse) |
| wakeEvent | input | 1 | External wake event |
| wakeDone | output | 1 | Wake arm completed (pulse) |
| wakeOk | output | 1 | Completion status, valid with wakeDone |
| ioInValid | input | 1 | I/O request from requester |
| ioInData | input | DATA_W | I/O request payload |
| ioInReady | output | 1 | Queue can take a request |
| ioOutValid | output | 1 | I/O request toward device |
| ioOutData | output | DATA_W | Payload toward device |
| ioOutReady | input | 1 | Device takes the request |
| saveCtx | output | 1 | Save-context strobe |
| restoreCtx | output | 1 | Restore-context strobe |
| curState | output | 3 | Current state code |
| entryCount | output | CNT_W | Low-power entry counter |

## Verification
A wrong sequencer state shows up within two cycles of a set request. It appears as a context strobe on the wrong side of the state change, a missing or early response, or a state code that moves when it should not. A corrupted lock or queue pointer shows up as a reordered or lost payload, or as a payload leaking out while the device is asleep or a query is outstanding. A stuck wake arm shows up as a missing or doubled completion pulse, or as a device that stays unpowered after the wake event. The counter is read after each walked sequence and compared with the number of deeper moves actually made, including a narrow instance driven past its ceiling.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [2:0] {
    PS_FULL   = 3'd0,
    PS_LIGHT  = 3'd1,
    PS_DEEP   = 3'd2,
    PS_BUSOFF = 3'd3,
    PS_UNPWR  = 3'd4
  } pwrState_e;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_SAVE    = 2'd1,
    SEQ_RESTORE = 2'd2
  } seqState_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic      loadState;
    pwrState_e nextState;
    logic      bumpCount;
    logic      drainEn;
  } dpStrobe_t;

endpackage

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
  import pwr_state_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       capD1,
  input  logic       capD2,
  input  logic       capWake,
  input  logic       auxPowerOff,
  input  logic       reqValid,
  input  logic       reqOp,
  input  logic [2:0] reqTarget,
  output logic       reqReady,
  output logic       rspValid,
  output logic       rspOk,
  input  logic       wakeArm,
  input  logic       wakeEvent,
  output logic       wakeDone,
  output logic       wakeOk,
  output logic       saveCtx,
  output logic       restoreCtx,
  input  pwrState_e  curState,
  output dpStrobe_t  strobe
);

  seqState_e seqQ;
  logic      lockValid;
  logic [2:0] lockTarget;
  pwrState_e pendTarget;
  logic      hostOwned;
  logic      rspValidQ, rspOkQ, saveQ, restoreQ;
  logic      wakePending, wakeDoneQ, wakeOkQ;

  logic tgtLegal, conflict, allowed, wakeHit, wakeReturn, accept;
  logic goDeeper, goShallower;

  always_comb begin
    tgtLegal = (reqTarget <= 3'd3)
             && (reqTarget != 3'd1 || capD1)
             && (reqTarget != 3'd2 || capD2);
    conflict    = lockValid && (reqTarget != lockTarget);
    allowed     = tgtLegal && !conflict && (curState != PS_UNPWR);
    goDeeper    = reqTarget > curState;
    goShallower = reqTarget < curState;
    wakeHit     = wakeEvent && wakePending && capWake;
    wakeReturn  = wakeHit && (seqQ == SEQ_IDLE) && (curState != PS_FULL);
    reqReady    = (seqQ == SEQ_IDLE) && !wakeReturn;
    accept      = reqValid && reqReady;
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ       <= SEQ_IDLE;
      lockValid  <= 1'b0;
      lockTarget <= 3'd0;
      pendTarget <= PS_FULL;
      hostOwned  <= 1'b0;
      rspValidQ  <= 1'b0;
      rspOkQ     <= 1'b0;
      saveQ      <= 1'b0;
      restoreQ   <= 1'b0;
    end else begin
      rspValidQ <= 1'b0;
      saveQ     <= 1'b0;
      restoreQ  <= 1'b0;
      case (seqQ)
        SEQ_IDLE: begin
          if (wakeReturn) begin
            seqQ      <= SEQ_RESTORE;
            hostOwned <= 1'b0;
            lockValid <= 1'b0;
          end else if (accept) begin
            if (!reqOp) begin
              rspValidQ <= 1'b1;
              rspOkQ    <= allowed;
              if (allowed) begin
                lockValid  <= 1'b1;
                lockTarget <= reqTarget;
              end
            end else if (!allowed) begin
              rspValidQ <= 1'b1;
              rspOkQ    <= 1'b0;
            end else begin
              lockValid  <= 1'b0;
              pendTarget <= pwrState_e'(reqTarget);
              if (goDeeper) begin
                seqQ  <= SEQ_SAVE;
                saveQ <= 1'b1;
              end else if (goShallower) begin
                seqQ      <= SEQ_RESTORE;
                hostOwned <= 1'b1;
              end else begin
                rspValidQ <= 1'b1;
                rspOkQ    <= 1'b1;
              end
            end
          end
        end
        SEQ_SAVE: begin
          seqQ      <= SEQ_IDLE;
          rspValidQ <= 1'b1;
          rspOkQ    <= 1'b1;
        end
        SEQ_RESTORE: begin
          seqQ     <= SEQ_IDLE;
          restoreQ <= 1'b1;
          if (hostOwned) begin
            rspValidQ <= 1'b1;
            rspOkQ    <= 1'b1;
          end
        end
        default: seqQ <= SEQ_IDLE;
      endcase
    end
  end

  // single pending wake arm
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakePending <= 1'b0;
      wakeDoneQ   <= 1'b0;
      wakeOkQ     <= 1'b0;
    end else begin
      wakeDoneQ <= 1'b0;
      if (wakePending) begin
        if (!capWake) begin
          wakePending <= 1'b0;
          wakeDoneQ   <= 1'b1;
          wakeOkQ     <= 1'b0;
        end else if (wakeEvent) begin
          wakePending <= 1'b0;
          wakeDoneQ   <= 1'b1;
          wakeOkQ     <= 1'b1;
        end
      end else if (wakeArm) begin
        if (capWake) begin
          wakePending <= 1'b1;
        end else begin
          wakeDoneQ <= 1'b1;
          wakeOkQ   <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strobe.loadState = 1'b0;
    strobe.nextState = curState;
    strobe.bumpCount = 1'b0;
    strobe.drainEn   = (curState == PS_FULL) && (seqQ == SEQ_IDLE) && !lockValid;
    if (seqQ == SEQ_IDLE) begin
      if (wakeReturn) begin
        strobe.loadState = 1'b1;
        strobe.nextState = PS_FULL;
      end else if (accept && reqOp && allowed && goShallower) begin
        strobe.loadState = 1'b1;
        strobe.nextState = pwrState_e'(reqTarget);
      end else if (!accept && auxPowerOff && curState == PS_BUSOFF) begin
        strobe.loadState = 1'b1;
        strobe.nextState = PS_UNPWR;
      end
    end else if (seqQ == SEQ_SAVE) begin
      strobe.loadState = 1'b1;
      strobe.nextState = pendTarget;
      strobe.bumpCount = 1'b1;
    end
  end

  assign rspValid   = rspValidQ;
  assign rspOk      = rspOkQ;
  assign saveCtx    = saveQ;
  assign restoreCtx = restoreQ;
  assign wakeDone   = wakeDoneQ;
  assign wakeOk     = wakeOkQ;

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(saveCtx && restoreCtx));

  assert_wake_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |-> ($past(wakePending) || ($past(wakeArm) && !$past(capWake))));

  assert_save_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    saveCtx |=> !saveCtx);

endmodule

// File: rtl/pwr_datapath.sv
module pwr_datapath
  import pwr_state_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int QUEUE_DEPTH = 4,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              ioInValid,
  input  logic [DATA_W-1:0] ioInData,
  output logic              ioInReady,
  output logic              ioOutValid,
  output logic [DATA_W-1:0] ioOutData,
  input  logic              ioOutReady,
  output pwrState_e         curState,
  output logic [CNT_W-1:0]  entryCount
);

  localparam int PTR_W  = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int FILL_W = $clog2(QUEUE_DEPTH + 1);
  localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(QUEUE_DEPTH - 1);
  localparam logic [FILL_W-1:0] FULL_FILL = FILL_W'(QUEUE_DEPTH);
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] slotMem [QUEUE_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [FILL_W-1:0] fill;
  logic              push, pop;
  pwrState_e         stateQ;
  logic [CNT_W-1:0]  countQ;

  assign ioInReady  = (fill != FULL_FILL);
  assign push       = ioInValid && ioInReady;
  assign ioOutValid = strobe.drainEn && (fill != '0);
  assign pop        = ioOutValid && ioOutReady;
  assign ioOutData  = slotMem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) slotMem[wrPtr] <= ioInData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= PS_FULL;
      countQ <= '0;
    end else begin
      if (strobe.loadState) stateQ <= strobe.nextState;
      if (strobe.bumpCount && countQ != CNT_MAX) countQ <= countQ + 1'b1;
    end
  end

  assign curState   = stateQ;
  assign entryCount = countQ;

  assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FULL_FILL);

  assert_io_only_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    ioOutValid |-> (stateQ == PS_FULL));

  assert_count_monotonic_R12: assert property (@(posedge clk) disable iff (!rstN)
    countQ >= $past(countQ));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int QUEUE_DEPTH = 4,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capD1,
  input  logic              capD2,
  input  logic              capWake,
  input  logic              auxPowerOff,
  input  logic              reqValid,
  input  logic              reqOp,
  input  logic [2:0]        reqTarget,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspOk,
  input  logic              wakeArm,
  input  logic              wakeEvent,
  output logic              wakeDone,
  output logic              wakeOk,
  input  logic              ioInValid,
  input  logic [DATA_W-1:0] ioInData,
  output logic              ioInReady,
  output logic              ioOutValid,
  output logic [DATA_W-1:0] ioOutData,
  input  logic              ioOutReady,
  output logic              saveCtx,
  output logic              restoreCtx,
  output logic [2:0]        curState,
  output logic [CNT_W-1:0]  entryCount
);

  dpStrobe_t strobe;
  pwrState_e stateNow;

  pwr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .capD1(capD1), .capD2(capD2), .capWake(capWake), .auxPowerOff(auxPowerOff),
    .reqValid(reqValid), .reqOp(reqOp), .reqTarget(reqTarget), .reqReady(reqReady),
    .rspValid(rspValid), .rspOk(rspOk),
    .wakeArm(wakeArm), .wakeEvent(wakeEvent), .wakeDone(wakeDone), .wakeOk(wakeOk),
    .saveCtx(saveCtx), .restoreCtx(restoreCtx),
    .curState(stateNow), .strobe(strobe)
  );

  pwr_datapath #(.DATA_W(DATA_W), .QUEUE_DEPTH(QUEUE_DEPTH), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ioInValid(ioInValid), .ioInData(ioInData), .ioInReady(ioInReady),
    .ioOutValid(ioOutValid), .ioOutData(ioOutData), .ioOutReady(ioOutReady),
    .curState(stateNow), .entryCount(entryCount)
  );

  assign curState = stateNow;

  assert_save_before_deeper_R4: assert property (@(posedge clk) disable iff (!rstN)
    (curState > $past(curState) && curState != 3'd4) |-> $past(saveCtx));

  assert_unpowered_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curState) == 3'd4 && curState != 3'd4) |-> (curState == 3'd0 && $past(wakeEvent)));

  assert_restore_after_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curState < $past(curState)) |=> restoreCtx);

endmodule

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic capD1 = 1, capD2 = 1, capWake = 1, auxPowerOff = 0;
  logic reqValid = 0, reqOp = 0;
  logic [2:0] reqTarget = 0;
  logic wakeArm = 0, wakeEvent = 0;
  logic ioInValid = 0, ioOutReady = 0;
  logic [7:0] ioInData = 0;

  logic reqReady, rspValid, rspOk, wakeDone, wakeOk, ioInReady, ioOutValid;
  logic saveCtx, restoreCtx;
  logic [7:0] ioOutData;
  logic [2:0] curState;
  logic [15:0] entryCount;

  logic satReqReady, satRspValid, satRspOk, satWakeDone, satWakeOk, satInReady, satOutValid;
  logic satSave, satRestore;
  logic [7:0] satOutData;
  logic [2:0] satState;
  logic [2:0] satCount;

  pwr_state_ctrl dut_i (
    .clk(clk), .rstN(rstN), .capD1(capD1), .capD2(capD2), .capWake(capWake),
    .auxPowerOff(auxPowerOff), .reqValid(reqValid), .reqOp(reqOp), .reqTarget(reqTarget),
    .reqReady(reqReady), .rspValid(rspValid), .rspOk(rspOk), .wakeArm(wakeArm),
    .wakeEvent(wakeEvent), .wakeDone(wakeDone), .wakeOk(wakeOk), .ioInValid(ioInValid),
    .ioInData(ioInData), .ioInReady(ioInReady), .ioOutValid(ioOutValid),
    .ioOutData(ioOutData), .ioOutReady(ioOutReady), .saveCtx(saveCtx),
    .restoreCtx(restoreCtx), .curState(curState), .entryCount(entryCount)
  );

  // narrow counter copy driven by the same stimulus, for the saturation check
  pwr_state_ctrl #(.CNT_W(3)) satDut_i (
    .clk(clk), .rstN(rstN), .capD1(capD1), .capD2(capD2), .capWake(capWake),
    .auxPowerOff(auxPowerOff), .reqValid(reqValid), .reqOp(reqOp), .reqTarget(reqTarget),
    .reqReady(satReqReady), .rspValid(satRspValid), .rspOk(satRspOk), .wakeArm(wakeArm),
    .wakeEvent(wakeEvent), .wakeDone(satWakeDone), .wakeOk(satWakeOk), .ioInValid(ioInValid),
    .ioInData(ioInData), .ioInReady(satInReady), .ioOutValid(satOutValid),
    .ioOutData(satOutData), .ioOutReady(ioOutReady), .saveCtx(satSave),
    .restoreCtx(satRestore), .curState(satState), .entryCount(satCount)
  );

  int testCnt = 0;
  int failCnt = 0;
  int wakeDoneCnt = 0;
  logic lastWakeOk = 0;

  always @(negedge clk) begin
    if (rstN && wakeDone) begin
      wakeDoneCnt++;
      lastWakeOk = wakeOk;
    end
  end

  task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
    testCnt++;
    if (!cond) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReq(input logic op, input logic [2:0] tgt, output logic ok, output logic [2:0] st);
    @(negedge clk);
    reqValid = 1; reqOp = op; reqTarget = tgt;
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 4 && !rspValid; i++) @(negedge clk);
    ok = rspValid && rspOk;
    st = curState;
  endtask

  task automatic pulseWake(input bit arm, input bit evt);
    @(negedge clk);
    wakeArm = arm; wakeEvent = evt;
    @(negedge clk);
    wakeArm = 0; wakeEvent = 0;
  endtask

  // {op, target, capD1, capD2, expOk, expState}
  localparam int NVEC = 14;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b0_001_1_1_1_000, // R2 R3 query light sleep, locks
    10'b1_010_1_1_0_000, // R3 other target refused
    10'b1_001_1_1_1_001, // R4 matching set
    10'b1_010_1_1_1_010,
    10'b1_011_1_1_1_011, // R6 lands in 3
    10'b1_100_1_1_0_011, // R6 code 4 refused
    10'b1_000_1_1_1_000, // R5
    10'b1_001_0_1_0_000, // R7 unsupported
    10'b0_010_1_0_0_000, // R7 R2 query unsupported
    10'b0_101_1_1_0_000, // R2 illegal code
    10'b1_000_1_1_1_000, // same state
    10'b0_011_1_1_1_000, // R2 query 3
    10'b1_011_1_1_1_011,
    10'b1_000_1_1_1_000
  };

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic ok;
    logic [2:0] st;
    logic [7:0] got [$];
    int n;
    bit seen;

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(curState == 0, "R1", "state", curState, 0);
    chk(entryCount == 0, "R1", "count", entryCount, 0);
    chk(!saveCtx && !restoreCtx && !rspValid && !ioOutValid, "R1", "outputs idle",
        {saveCtx, restoreCtx, rspValid, ioOutValid}, 0);
    chk(reqReady == 1, "R1", "reqReady", reqReady, 1);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      capD1 = VEC[v][5]; capD2 = VEC[v][4];
      doReq(VEC[v][9], VEC[v][8:6], ok, st);
      chk(ok == VEC[v][3], "R2/R3/R6/R7", $sformatf("vector %0d ok", v), ok, VEC[v][3]);
      chk(st == VEC[v][2:0], "R4/R5/R6/R7", $sformatf("vector %0d state", v), st, VEC[v][2:0]);
    end
    capD1 = 1; capD2 = 1;
    chk(entryCount == 4, "R12", "count after table", entryCount, 4);

    // R4 exact timing
    @(negedge clk);
    reqValid = 1; reqOp = 1; reqTarget = 3'd1;
    @(negedge clk);
    reqValid = 0;
    chk(saveCtx == 1 && curState == 0, "R4", "save before change", {saveCtx, curState}, 8);
    @(negedge clk);
    chk(saveCtx == 0 && curState == 1, "R4", "state after save", {saveCtx, curState}, 1);
    chk(rspValid && rspOk, "R4", "response", {rspValid, rspOk}, 3);
    chk(entryCount == 5, "R12", "count bump", entryCount, 5);

    // R9 R10 queue while in light sleep
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ioInValid = 1; ioInData = 8'hA0 + 8'(i);
    end
    @(negedge clk);
    ioInValid = 0;
    chk(ioInReady == 0, "R10", "ready low when full", ioInReady, 0);
    chk(ioOutValid == 0, "R9", "held while asleep", ioOutValid, 0);
    ioInValid = 1; ioInData = 8'hFF;
    repeat (2) @(negedge clk);
    ioInValid = 0;

    // R5 exact timing
    reqValid = 1; reqOp = 1; reqTarget = 3'd0;
    @(negedge clk);
    reqValid = 0;
    chk(curState == 0 && restoreCtx == 0 && rspValid == 0, "R5", "change before restore",
        {curState, restoreCtx, rspValid}, 0);
    @(negedge clk);
    chk(restoreCtx == 1 && rspValid && rspOk, "R5", "restore and response",
        {restoreCtx, rspValid, rspOk}, 7);

    ioOutReady = 1;
    for (int k = 0; k < 8; k++) begin
      if (ioOutValid) got.push_back(ioOutData);
      @(negedge clk);
    end
    chk(got.size() == 4, "R9", "released count", got.size(), 4);
    for (int i = 0; i < 4 && i < got.size(); i++)
      chk(got[i] == 8'hA0 + 8'(i), "R9", $sformatf("order %0d", i), got[i], 8'hA0 + i);

    // R3 lock holds I/O
    doReq(0, 3'd2, ok, st);
    chk(ok == 1, "R3", "query ok", ok, 1);
    @(negedge clk);
    ioInValid = 1; ioInData = 8'h55;
    @(negedge clk);
    ioInValid = 0;
    seen = 0;
    repeat (3) begin
      @(negedge clk);
      if (ioOutValid) seen = 1;
    end
    chk(!seen, "R3", "io held under lock", seen, 0);
    doReq(1, 3'd1, ok, st);
    chk(ok == 0 && st == 0, "R3", "mismatch set refused", {ok, st}, 0);
    doReq(1, 3'd2, ok, st);
    chk(ok == 1 && st == 2, "R3", "matching set", {ok, st}, 10);
    doReq(1, 3'd0, ok, st);
    n = 0;
    for (int k = 0; k < 6; k++) begin
      if (ioOutValid && ioOutData == 8'h55) n++;
      @(negedge clk);
    end
    chk(n == 1, "R3", "held item released once", n, 1);

    // R11 wake arm
    pulseWake(1, 0);
    pulseWake(1, 0);
    pulseWake(0, 1);
    repeat (2) @(negedge clk);
    chk(wakeDoneCnt == 1 && lastWakeOk, "R11", "single completion ok", wakeDoneCnt, 1);
    pulseWake(1, 0);
    @(negedge clk);
    capWake = 0;
    repeat (2) @(negedge clk);
    chk(wakeDoneCnt == 2 && !lastWakeOk, "R11", "withdrawn fails", wakeDoneCnt, 2);
    pulseWake(1, 0);
    repeat (2) @(negedge clk);
    chk(wakeDoneCnt == 3 && !lastWakeOk, "R11", "arm without capability", wakeDoneCnt, 3);
    capWake = 1;

    // R6 R8 unpowered state
    doReq(1, 3'd3, ok, st);
    chk(ok && st == 3, "R6", "to bus-off", {ok, st}, 11);
    auxPowerOff = 1;
    repeat (3) @(negedge clk);
    chk(curState == 4, "R6", "aux loss to unpowered", curState, 4);
    chk(entryCount == 7, "R6", "no count on aux loss", entryCount, 7);
    doReq(1, 3'd0, ok, st);
    chk(ok == 0 && st == 4, "R8", "set refused when unpowered", {ok, st}, 4);
    auxPowerOff = 0;
    pulseWake(1, 0);
    @(negedge clk);
    wakeEvent = 1;
    @(negedge clk);
    wakeEvent = 0;
    chk(curState == 0 && restoreCtx == 0, "R8", "wake return", {curState, restoreCtx}, 0);
    @(negedge clk);
    chk(restoreCtx == 1, "R8", "restore after wake", restoreCtx, 1);
    chk(wakeDoneCnt == 4 && lastWakeOk, "R11", "wake completes ok", wakeDoneCnt, 4);

    // R13 wake from deeper sleep
    doReq(1, 3'd2, ok, st);
    pulseWake(1, 0);
    pulseWake(0, 1);
    @(negedge clk);
    chk(curState == 0, "R13", "wake from state 2", curState, 0);

    // R12 more entries, saturation on narrow copy
    for (int i = 0; i < 2; i++) begin
      doReq(1, 3'd1, ok, st);
      doReq(1, 3'd0, ok, st);
    end
    @(negedge clk);
    chk(entryCount == 10, "R12", "wide count", entryCount, 10);
    chk(satCount == 3'd7, "R12", "narrow count saturates", satCount, 7);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule